// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is one core's private event timer. Each core owns one copy, at its own 256-byte slot of the register space. Two stages are chained. A prescaler divides the input clock into ticks at a programmable rate. A 31-bit down-counter is decremented by those ticks and flags an event when it runs out.

The down-counter is loaded from a buffer register. Writing the buffer alone only stores the value, which is used on the next start or reload. Setting the top bit of the write data copies the value into the live counter at once. In auto-reload mode the counter refills from the buffer on the tick that empties it, so events keep coming at a fixed period. Without that mode it fires once and waits at zero until software restarts it. Every write to the tick buffer, the count buffer or the control register raises an acknowledge bit that software polls and then clears by writing 1.

Top module: `core_tick_timer`

## Requirements
- R1: After a synchronous reset, every register reads as zero and `irq` is low.
- R2: While control bit 0 is set, the prescaler emits one tick every (tick buffer + 1) clocks. The first tick lands (tick buffer + 1) clocks after the write that sets the bit. While the bit is clear, the prescaler is held at its start.
- R3: A write to offset 0x08 stores data bits 30:0 as the buffered count, and bit 31 always reads back as 0. If data bit 31 is set, the live counter takes bits 30:0 on that same edge, and this overrides any tick decrement in that cycle.
- R4: When a control write (offset 0x20) changes bit 1 from 0 to 1, the live counter reloads from the buffer. Starting both stages with buffer N ≥ 1 sets the event flag exactly N·(tick buffer + 1) clocks after that write.
- R5: With control bit 2 clear, the counter stays at zero after it expires. No further event follows until it is reloaded.
- R6: With control bit 2 set, the counter reloads from the buffer on the tick that empties it. Events then repeat every N·(tick buffer + 1) clocks.
- R7: Clearing control bit 0 freezes the live counter. Setting bit 0 again while bit 1 stays set resumes the count from the frozen value.
- R8: The event flag is bit 0 of offset 0x30, and writing 1 there clears it. If an expiry falls in the same cycle as the clear, the flag stays set.
- R9: `irq` is high exactly while the event flag and bit 0 of offset 0x34 are both set.
- R10: Offset 0x40 holds write acknowledges. Bit 0 is set by a write to 0x00, bit 1 by a write to 0x08 and bit 3 by a write to 0x20. Each bit is cleared by writing 1 to it. Writes to any other offset set no acknowledge bit.
- R11: Reads return the tick buffer at 0x00, the buffered count at 0x08, control bits 2:0 at 0x20, the flag at 0x30, the enable at 0x34 and the acknowledges at 0x40. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the timer's window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address, valid during a read strobe |
| irq | output | 1 | Event interrupt to the owning core |

## Verification
All stimulus is applied as writes captured on one rising edge. Reads are combinational and consume no edge. A register write is visible on a read right after its edge. An expiry shows on `irq` right after edge N·(tick buffer + 1), counted from the start write, because the tick is combinational from the prescaler count and only the flag register sits before the output. The bench counts edges from each write and checks `irq` at every edge up to and including that one, so a result that comes one cycle early or late is reported. A sweep over tick buffers 0–3, counts 1–3 and both modes checks the period. Separate sequences check the same-edge cases: an update write racing a tick, a flag clear racing an expiry, and a pause followed by a resume.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_TICKBUF = 8'h00;
    localparam logic [OFS_W-1:0] OFS_CNTBUF  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 8'h20;
    localparam logic [OFS_W-1:0] OFS_FLAG    = 8'h30;
    localparam logic [OFS_W-1:0] OFS_IEN     = 8'h34;
    localparam logic [OFS_W-1:0] OFS_WACK    = 8'h40;

    localparam int ACK_W       = 4;
    localparam int ACK_TICKBUF = 0;
    localparam int ACK_CNTBUF  = 1;
    localparam int ACK_CTRL    = 3;

    // bit 2: auto-reload, bit 1: counter run, bit 0: prescaler run
    typedef struct packed {
        logic auto_reload;
        logic cnt_run;
        logic tick_run;
    } ctrl_t;

    function automatic logic [ACK_W-1:0] ack_mask(input logic [OFS_W-1:0] ofs);
        logic [ACK_W-1:0] m;
        m = '0;
        case (ofs)
            OFS_TICKBUF: m[ACK_TICKBUF] = 1'b1;
            OFS_CNTBUF:  m[ACK_CNTBUF]  = 1'b1;
            OFS_CTRL:    m[ACK_CTRL]    = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/ltmr_prescale.sv
module ltmr_prescale #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [TICK_W-1:0] limit,
    output logic              tick
);
    logic [TICK_W-1:0] pcnt_q;
    logic              wrap;

    assign wrap = (pcnt_q >= limit);
    assign tick = run && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pcnt_q <= '0;
        else if (wrap)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    // R2
    pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(limit)) |-> (pcnt_q <= limit));
endmodule

// File: rtl/ltmr_irqcnt.sv
module ltmr_irqcnt #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             auto_reload,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             last;

    assign step   = tick && run && !load && (cnt_q != '0);
    assign last   = (cnt_q == CNT_W'(1));
    assign expire = step && last;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step) begin
            if (last)
                cnt_q <= auto_reload ? reload_val : '0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));
    // R6
    auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_reload) |=> (cnt_q == $past(reload_val)));
    // R5
    oneshot_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !auto_reload) |=> (cnt_q == '0));
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(tick && run) && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ltmr_regs.sv
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    output logic [TICK_W-1:0] tick_buf,
    output logic [CNT_W-1:0]  cnt_buf,
    output ctrl_t             ctrl,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              irq_out
);
    localparam int UPD_BIT = DATA_W - 1;

    logic             wr_en;
    logic             upd_req;
    logic             start_rise;
    logic             flag_q;
    logic             ien_q;
    logic [ACK_W-1:0] wack_q;
    logic [ACK_W-1:0] wack_d;
    logic [2:0]       ctrl_bits;

    assign wr_en      = bus_sel && bus_wr;
    assign upd_req    = wr_en && (bus_addr == OFS_CNTBUF) && bus_wdata[UPD_BIT];
    assign start_rise = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[1] && !ctrl.cnt_run;
    assign load       = upd_req || start_rise;
    assign load_val   = upd_req ? bus_wdata[CNT_W-1:0] : cnt_buf;
    assign irq_out    = flag_q && ien_q;
    assign ctrl_bits  = ctrl;

    always_comb begin
        wack_d = wack_q;
        if (wr_en && bus_addr == OFS_WACK)
            wack_d = wack_d & ~bus_wdata[ACK_W-1:0];
        if (wr_en)
            wack_d = wack_d | ack_mask(bus_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_buf <= '0;
            cnt_buf  <= '0;
            ctrl     <= '0;
            ien_q    <= 1'b0;
            flag_q   <= 1'b0;
            wack_q   <= '0;
        end else begin
            wack_q <= wack_d;
            if (wr_en && bus_addr == OFS_TICKBUF) tick_buf <= bus_wdata[TICK_W-1:0];
            if (wr_en && bus_addr == OFS_CNTBUF)  cnt_buf  <= bus_wdata[CNT_W-1:0];
            if (wr_en && bus_addr == OFS_CTRL)    ctrl     <= ctrl_t'(bus_wdata[2:0]);
            if (wr_en && bus_addr == OFS_IEN)     ien_q    <= bus_wdata[0];
            if (expire)
                flag_q <= 1'b1;
            else if (wr_en && bus_addr == OFS_FLAG && bus_wdata[0])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_TICKBUF: bus_rdata = DATA_W'(tick_buf);
                OFS_CNTBUF:  bus_rdata = DATA_W'(cnt_buf);
                OFS_CTRL:    bus_rdata = DATA_W'(ctrl_bits);
                OFS_FLAG:    bus_rdata = DATA_W'(flag_q);
                OFS_IEN:     bus_rdata = DATA_W'(ien_q);
                OFS_WACK:    bus_rdata = DATA_W'(wack_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);
    // R10
    ack_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == OFS_TICKBUF) |=> wack_q[ACK_TICKBUF]);
    // R10
    ack_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == OFS_CTRL) |=> wack_q[ACK_CTRL]);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import ltmr_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic [TICK_W-1:0] tick_buf;
    logic [CNT_W-1:0]  cnt_buf;
    logic [CNT_W-1:0]  load_val;
    ctrl_t             ctrl;
    logic              load;
    logic              tick;
    logic              expire;

    ltmr_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire(expire), .tick_buf(tick_buf), .cnt_buf(cnt_buf),
        .ctrl(ctrl), .load(load), .load_val(load_val), .irq_out(irq)
    );

    ltmr_prescale #(.TICK_W(TICK_W)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl.tick_run), .limit(tick_buf), .tick(tick)
    );

    ltmr_irqcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl.cnt_run),
        .auto_reload(ctrl.auto_reload), .load(load), .load_val(load_val),
        .reload_val(cnt_buf), .expire(expire)
    );

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(irq)) |-> $past(expire) || $past(bus_sel && bus_wr && bus_addr == OFS_IEN));
endmodule

// File: tb/sim_core_tick_timer.sv
module sim_core_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    core_tick_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_TB = 8'h00, A_CB = 8'h08, A_CT = 8'h20,
                           A_FL = 8'h30, A_EN = 8'h34, A_WA = 8'h40;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called in the negedge phase; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R11 unused offset
        chk("R1 irq", {31'b0, irq}, 0);
        rd(A_TB, v); chk("R1 tickbuf", v, 0);
        rd(A_CB, v); chk("R1 cntbuf", v, 0);
        rd(A_CT, v); chk("R1 ctrl", v, 0);
        rd(A_FL, v); chk("R1 flag", v, 0);
        rd(A_EN, v); chk("R1 enable", v, 0);
        rd(A_WA, v); chk("R1 wack", v, 0);
        rd(8'h10, v); chk("R11 unused", v, 0);

        // R10 acknowledges, R3 bit31 not stored, R11 readback
        wr(A_TB, 32'h7);               rd(A_WA, v); chk("R10 tick ack", v, 32'h1);
        wr(A_CB, 32'h8000_0005);       rd(A_WA, v); chk("R10 cnt ack", v, 32'h3);
        rd(A_CB, v); chk("R3 buf readback", v, 32'h5);
        wr(A_EN, 32'h0);               rd(A_WA, v); chk("R10 no ack", v, 32'h3);
        wr(A_CT, 32'h0);               rd(A_WA, v); chk("R10 ctrl ack", v, 32'hB);
        wr(A_WA, 32'h2);               rd(A_WA, v); chk("R10 w1c", v, 32'h9);
        wr(A_WA, 32'h9);               rd(A_WA, v); chk("R10 w1c all", v, 32'h0);
        rd(A_TB, v); chk("R11 tickbuf", v, 32'h7);

        // R9 enable gate
        wr(A_TB, 0); wr(A_CB, 1); wr(A_CT, 3);
        step(); chk("R9 gated irq", {31'b0, irq}, 0);
        rd(A_FL, v); chk("R8 flag set", v, 1);
        wr(A_EN, 1); chk("R9 enabled irq", {31'b0, irq}, 1);
        wr(A_CT, 0); wr(A_FL, 1);
        rd(A_FL, v); chk("R8 flag clear", v, 0);
        chk("R9 irq low", {31'b0, irq}, 0);

        // R2 R4 R5 R6 R8 sweep
        for (int tb = 0; tb < 4; tb++) begin
            for (int n = 1; n < 4; n++) begin
                for (int md = 0; md < 2; md++) begin
                    wr(A_CT, 0); wr(A_FL, 1); wr(A_EN, 1);
                    wr(A_TB, tb); wr(A_CB, n);
                    p = n * (tb + 1);
                    wr(A_CT, 32'(3 | (md << 2)));
                    for (int c = 1; c <= p; c++) begin
                        step();
                        chk("R2 R4 first expiry", {31'b0, irq}, {31'b0, c == p});
                    end
                    if (md == 0) begin
                        for (int c = 1; c <= 2 * p; c++) begin
                            step(); chk("R5 flag held", {31'b0, irq}, 1);
                        end
                        wr(A_FL, 1);
                        for (int c = 1; c <= 3 * p; c++) begin
                            chk("R5 no refire", {31'b0, irq}, 0);
                            step();
                        end
                    end else begin
                        wr(A_FL, 1);
                        chk("R8 R6 after clear", {31'b0, irq}, {31'b0, p == 1});
                        for (int c = p + 2; c <= 2 * p; c++) begin
                            step();
                            chk("R6 period", {31'b0, irq}, {31'b0, c == 2 * p});
                        end
                    end
                end
            end
        end

        // R3 update write overrides a tick
        wr(A_CT, 0); wr(A_FL, 1); wr(A_TB, 0); wr(A_CB, 10); wr(A_CT, 3);
        step(); step(); step();
        wr(A_CB, 32'h8000_0002);
        step(); chk("R3 update early", {31'b0, irq}, 0);
        step(); chk("R3 update expiry", {31'b0, irq}, 1);
        rd(A_CB, v); chk("R3 buf value", v, 32'h2);

        // R7 pause and resume
        wr(A_CT, 0); wr(A_FL, 1); wr(A_CB, 6); wr(A_CT, 3);
        step(); step();
        wr(A_CT, 2);
        for (int c = 0; c < 8; c++) begin
            step(); chk("R7 frozen", {31'b0, irq}, 0);
        end
        wr(A_CT, 3);
        step(); chk("R7 resume c1", {31'b0, irq}, 0);
        step(); chk("R7 resume c2", {31'b0, irq}, 0);
        step(); chk("R7 resume expiry", {31'b0, irq}, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule